// File: doc/BRIEF.md
# Micro-op Counted Retire Control Unit

This block tracks in-flight instructions of an out-of-order core so they leave the machine in program order. On dispatch, an instruction reserves as many capacity units as it has micro-ops. Its record is written into a circular slot queue. The slot index is returned as a token that travels with the instruction. The queue has twice as many indices as there are capacity units. The write pointer advances by the micro-op count, or by one index for an instruction with no micro-ops.

Execution units report completion by presenting a token on the executed input. Each cycle, the unit walks forward from the head record. It retires records that are both valid and executed, in order, up to a per-cycle limit; a limit of zero means no limit. Retired records are cleared, and their micro-op capacity returns to the free pool. That capacity can be used for dispatch from the next cycle.

Top module: `rcu_retire_unit`

## Requirements
- R1: After reset, `free_o` equals `CAP`, both the head and the next-free index are 0, and no retire lane is valid.
- R2: An accepted dispatch returns the current next-free index as `disp_token_o`. The index then advances by max(1, micro-op count), modulo `2*CAP`.
- R3: A dispatch with a micro-op count of 0 advances the index by exactly 1 and leaves `free_o` unchanged, both when it is dispatched and when it retires.
- R4: `disp_ready_o` is low when the requested micro-op count exceeds `free_o`. A refused request changes neither `free_o` nor the next token.
- R5: The head record retires only once it is valid and has been marked executed. A younger executed record never retires ahead of an older one that is not yet executed.
- R6: With `MAX_RET` nonzero, at most `MAX_RET` records retire per cycle. The remaining retirable records retire in following cycles, in order.
- R7: Capacity released by retirement shows in `free_o` in the cycle after the retire lanes are presented.
- R8: `exec_err_o` rises in the same cycle when an executed token addresses an empty slot or a slot already marked executed. Such a request changes no record.
- R9: With `MAX_RET` equal to 0, every consecutive retirable record from the head retires in a single cycle, up to the full queue length. Lane k carries the k-th retiring token.
- R10: A dispatch is refused when the queue indices would run out, that is, when the slots in use plus max(1, micro-op count) would exceed `2*CAP`. This holds even when capacity remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch request |
| disp_uops_i | input | UOP_W | Micro-op count of the request |
| disp_ready_o | output | 1 | Request accepted this cycle |
| disp_token_o | output | IDX_W | Token (slot index) given to the request |
| exec_valid_i | input | 1 | Executed report valid |
| exec_token_i | input | IDX_W | Token of the executed instruction |
| exec_err_o | output | 1 | Executed report hit an empty or already executed slot |
| ret_valid_o | output | LANES | Retire lane valid, lane 0 oldest |
| ret_token_o | output | LANES*IDX_W | Token retiring on each lane |
| free_o | output | UOP_W | Free micro-op capacity |

## Verification
A corrupted head pointer or a stale executed flag appears on the retire lanes within one cycle of the next executed report: the scoreboard sees a token out of dispatch order, or a token that was never dispatched. An error in capacity accounting shows in `free_o` one cycle after a dispatch or a retirement. It also shows as a wrong accept or refuse decision at the boundary requests, and as a token index that drifts after the pointer wraps. Executed reports that should be rejected are checked through `exec_err_o` in the same cycle. The absence of a premature retirement confirms that such a report changed nothing.

// File: rtl/rcu_pkg.sv
package rcu_pkg;
  // queue indices consumed by one record: zero micro-ops still take one index
  function automatic int unsigned slot_span(int unsigned n);
    return (n == 0) ? 1 : n;
  endfunction
endpackage

// File: rtl/rcu_rec_array.sv
module rcu_rec_array #(
  parameter int QLEN  = 16,
  parameter int IDX_W = 4,
  parameter int UOP_W = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [IDX_W-1:0]                 wr_idx_i,
  input  logic [UOP_W-1:0]                 wr_uops_i,
  input  logic                             mark_en_i,
  input  logic [IDX_W-1:0]                 mark_idx_i,
  input  logic [QLEN-1:0]                  clr_i,
  output logic [QLEN-1:0]                  valid_o,
  output logic [QLEN-1:0]                  done_o,
  output logic [QLEN-1:0][UOP_W-1:0]       uops_o,
  output logic                             mark_err_o
);
  logic [QLEN-1:0]            valid_q, done_q;
  logic [QLEN-1:0][UOP_W-1:0] uops_q;

  for (genvar i = 0; i < QLEN; i++) begin : g_slot
    logic hit_wr, hit_mark;
    assign hit_wr   = wr_en_i && (wr_idx_i == IDX_W'(i));
    assign hit_mark = mark_en_i && (mark_idx_i == IDX_W'(i)) && valid_q[i] && !done_q[i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        done_q[i]  <= 1'b0;
        uops_q[i]  <= '0;
      end else if (clr_i[i]) begin
        valid_q[i] <= 1'b0;
        done_q[i]  <= 1'b0;
        uops_q[i]  <= '0;
      end else if (hit_wr) begin
        valid_q[i] <= 1'b1;
        done_q[i]  <= 1'b0;
        uops_q[i]  <= wr_uops_i;
      end else if (hit_mark) begin
        done_q[i]  <= 1'b1;
      end
    end
  end

  assign mark_err_o = mark_en_i && (!valid_q[mark_idx_i] || done_q[mark_idx_i]);
  assign valid_o    = valid_q;
  assign done_o     = done_q;
  assign uops_o     = uops_q;

  assert_wr_empty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !valid_q[wr_idx_i]);

  assert_mark_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark_en_i && !mark_err_o) |=> done_q[$past(mark_idx_i)]);

  assert_err_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark_en_i && mark_err_o && !valid_q[mark_idx_i] && !(wr_en_i && wr_idx_i == mark_idx_i))
      |=> !done_q[$past(mark_idx_i)]);
endmodule

// File: rtl/rcu_retire_sel.sv
module rcu_retire_sel #(
  parameter int QLEN  = 16,
  parameter int IDX_W = 4,
  parameter int UOP_W = 4,
  parameter int CW    = 6,
  parameter int LANES = 2
) (
  input  logic [IDX_W-1:0]            head_i,
  input  logic [QLEN-1:0]             valid_i,
  input  logic [QLEN-1:0]             done_i,
  input  logic [QLEN-1:0][UOP_W-1:0]  uops_i,
  output logic [LANES-1:0]            fire_o,
  output logic [LANES-1:0][IDX_W-1:0] idx_o,
  output logic [QLEN-1:0]             clr_o,
  output logic [IDX_W-1:0]            next_head_o,
  output logic [CW-1:0]               freed_uops_o,
  output logic [CW-1:0]               freed_slots_o
);
  always_comb begin
    logic [IDX_W-1:0] p;
    logic [CW-1:0]    acc, sp, nx, fu;
    logic             go;
    p      = head_i;
    acc    = '0;
    fu     = '0;
    sp     = '0;
    nx     = '0;
    go     = 1'b1;
    fire_o = '0;
    idx_o  = '0;
    clr_o  = '0;
    for (int k = 0; k < LANES; k++) begin
      // stop at the first non-retirable record, never lap the queue
      if (go && (acc < CW'(QLEN)) && valid_i[p] && done_i[p]) begin
        sp        = CW'(rcu_pkg::slot_span(int'(uops_i[p])));
        fire_o[k] = 1'b1;
        idx_o[k]  = p;
        clr_o[p]  = 1'b1;
        fu        = fu + CW'(uops_i[p]);
        acc       = acc + sp;
        nx        = CW'(p) + sp;
        if (nx >= CW'(QLEN)) nx = nx - CW'(QLEN);
        p         = nx[IDX_W-1:0];
      end else begin
        go = 1'b0;
      end
    end
    next_head_o   = p;
    freed_uops_o  = fu;
    freed_slots_o = acc;
  end
endmodule

// File: rtl/rcu_disp_ctl.sv
module rcu_disp_ctl #(
  parameter int CAP   = 8,
  parameter int QLEN  = 16,
  parameter int IDX_W = 4,
  parameter int UOP_W = 4,
  parameter int CW    = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [UOP_W-1:0] uops_i,
  input  logic [CW-1:0]    freed_uops_i,
  input  logic [CW-1:0]    freed_slots_i,
  output logic             ready_o,
  output logic             fire_o,
  output logic [IDX_W-1:0] tail_o,
  output logic [UOP_W-1:0] avail_o,
  output logic [CW-1:0]    used_o
);
  logic [IDX_W-1:0] tail_q;
  logic [UOP_W-1:0] avail_q;
  logic [CW-1:0]    used_q, span, t_nx, a_nx, u_nx;

  assign span    = CW'(rcu_pkg::slot_span(int'(uops_i)));
  assign ready_o = (CW'(uops_i) <= CW'(avail_q)) && ((used_q + span) <= CW'(QLEN));
  assign fire_o  = req_i && ready_o;

  always_comb begin
    t_nx = CW'(tail_q) + span;
    if (t_nx >= CW'(QLEN)) t_nx = t_nx - CW'(QLEN);
    a_nx = CW'(avail_q) + freed_uops_i - (fire_o ? CW'(uops_i) : CW'(0));
    u_nx = used_q - freed_slots_i + (fire_o ? span : CW'(0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tail_q  <= '0;
      avail_q <= UOP_W'(CAP);
      used_q  <= '0;
    end else begin
      if (fire_o) tail_q <= t_nx[IDX_W-1:0];
      avail_q <= a_nx[UOP_W-1:0];
      used_q  <= u_nx;
    end
  end

  assign tail_o  = tail_q;
  assign avail_o = avail_q;
  assign used_o  = used_q;

  assert_avail_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CW'(avail_q) <= CW'(CAP));

  assert_used_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_q <= CW'(QLEN));

  assert_refuse_keeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ready_o) |=> $stable(tail_q));
endmodule

// File: rtl/rcu_retire_unit.sv
module rcu_retire_unit #(
  parameter int CAP     = 8,
  parameter int MAX_RET = 2,
  localparam int QLEN   = 2 * CAP,
  localparam int IDX_W  = $clog2(QLEN),
  localparam int UOP_W  = $clog2(CAP + 1),
  localparam int LANES  = (MAX_RET == 0) ? QLEN : MAX_RET
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        disp_valid_i,
  input  logic [UOP_W-1:0]            disp_uops_i,
  output logic                        disp_ready_o,
  output logic [IDX_W-1:0]            disp_token_o,
  input  logic                        exec_valid_i,
  input  logic [IDX_W-1:0]            exec_token_i,
  output logic                        exec_err_o,
  output logic [LANES-1:0]            ret_valid_o,
  output logic [LANES-1:0][IDX_W-1:0] ret_token_o,
  output logic [UOP_W-1:0]            free_o
);
  localparam int CW = IDX_W + 2;

  logic                       disp_fire;
  logic [IDX_W-1:0]           tail_w, head_q, head_nx;
  logic [CW-1:0]              used_w, freed_u, freed_s;
  logic [QLEN-1:0]            valid_w, done_w, clr_w;
  logic [QLEN-1:0][UOP_W-1:0] uops_w;

  rcu_disp_ctl #(.CAP(CAP), .QLEN(QLEN), .IDX_W(IDX_W), .UOP_W(UOP_W), .CW(CW)) u_disp (
    .clk_i, .rst_ni,
    .req_i(disp_valid_i), .uops_i(disp_uops_i),
    .freed_uops_i(freed_u), .freed_slots_i(freed_s),
    .ready_o(disp_ready_o), .fire_o(disp_fire), .tail_o(tail_w),
    .avail_o(free_o), .used_o(used_w)
  );

  rcu_rec_array #(.QLEN(QLEN), .IDX_W(IDX_W), .UOP_W(UOP_W)) u_recs (
    .clk_i, .rst_ni,
    .wr_en_i(disp_fire), .wr_idx_i(tail_w), .wr_uops_i(disp_uops_i),
    .mark_en_i(exec_valid_i), .mark_idx_i(exec_token_i),
    .clr_i(clr_w), .valid_o(valid_w), .done_o(done_w), .uops_o(uops_w),
    .mark_err_o(exec_err_o)
  );

  rcu_retire_sel #(.QLEN(QLEN), .IDX_W(IDX_W), .UOP_W(UOP_W), .CW(CW), .LANES(LANES)) u_sel (
    .head_i(head_q), .valid_i(valid_w), .done_i(done_w), .uops_i(uops_w),
    .fire_o(ret_valid_o), .idx_o(ret_token_o), .clr_o(clr_w),
    .next_head_o(head_nx), .freed_uops_o(freed_u), .freed_slots_o(freed_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) head_q <= '0;
    else         head_q <= head_nx;
  end

  assign disp_token_o = tail_w;

  assert_empty_aligned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (used_w == '0) |-> (head_q == tail_w));

  assert_head_retires_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_o[0] |-> (ret_token_o[0] == head_q));

  assert_free_grows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_o[0] && !disp_fire) |=> (free_o >= $past(free_o)));
endmodule

// File: tb/rcu_retire_unit_bench.sv
module rcu_retire_unit_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  // main instance: CAP=8, two retire lanes
  logic            a_dv = 0, a_ev = 0;
  logic [3:0]      a_du = 0, a_et = 0;
  logic            a_rdy, a_err;
  logic [3:0]      a_tok, a_free;
  logic [1:0]      a_rv;
  logic [1:0][3:0] a_rt;

  rcu_retire_unit #(.CAP(8), .MAX_RET(2)) u_rcu_retire_unit (
    .clk_i, .rst_ni,
    .disp_valid_i(a_dv), .disp_uops_i(a_du), .disp_ready_o(a_rdy), .disp_token_o(a_tok),
    .exec_valid_i(a_ev), .exec_token_i(a_et), .exec_err_o(a_err),
    .ret_valid_o(a_rv), .ret_token_o(a_rt), .free_o(a_free)
  );

  // unlimited instance: CAP=4, eight lanes
  logic            b_dv = 0, b_ev = 0;
  logic [2:0]      b_du = 0, b_et = 0;
  logic            b_rdy, b_err;
  logic [2:0]      b_tok, b_free;
  logic [7:0]      b_rv;
  logic [7:0][2:0] b_rt;

  rcu_retire_unit #(.CAP(4), .MAX_RET(0)) u_rcu_retire_unit_nolim (
    .clk_i, .rst_ni,
    .disp_valid_i(b_dv), .disp_uops_i(b_du), .disp_ready_o(b_rdy), .disp_token_o(b_tok),
    .exec_valid_i(b_ev), .exec_token_i(b_et), .exec_err_o(b_err),
    .ret_valid_o(b_rv), .ret_token_o(b_rt), .free_o(b_free)
  );

  // monitor: retire lanes compared in order against dispatch order
  always @(negedge clk_i) begin
    if (rst_ni) begin
      for (int l = 0; l < 2; l++) begin
        if (a_rv[l]) begin
          if (exp_q.size() == 0) check(1'b0, "R5", int'(a_rt[l]), -1);
          else begin
            int e;
            e = exp_q.pop_front();
            check(int'(a_rt[l]) == e, "R5", int'(a_rt[l]), e);
          end
        end
      end
      if (a_rv != 0) check($countones(a_rv) <= 2, "R6", $countones(a_rv), 2);
    end
  end

  task automatic disp_a(input int n, input bit exp_rdy, input int exp_tok);
    @(negedge clk_i);
    a_dv = 1'b1; a_du = 4'(n);
    #1;
    check(a_rdy == exp_rdy, "R4", int'(a_rdy), int'(exp_rdy));
    if (exp_rdy) begin
      check(int'(a_tok) == exp_tok, "R2", int'(a_tok), exp_tok);
      exp_q.push_back(exp_tok);
    end
    @(posedge clk_i); #1;
    a_dv = 1'b0;
  endtask

  task automatic exec_a(input int tok, input bit exp_err);
    @(negedge clk_i);
    a_ev = 1'b1; a_et = 4'(tok);
    #1;
    check(a_err == exp_err, "R8", int'(a_err), int'(exp_err));
    @(posedge clk_i); #1;
    a_ev = 1'b0;
  endtask

  task automatic disp_b(input bit exp_rdy, input int exp_tok);
    @(negedge clk_i);
    b_dv = 1'b1; b_du = 3'd0;
    #1;
    check(b_rdy == exp_rdy, "R10", int'(b_rdy), int'(exp_rdy));
    if (exp_rdy) check(int'(b_tok) == exp_tok, "R3", int'(b_tok), exp_tok);
    @(posedge clk_i); #1;
    b_dv = 1'b0;
  endtask

  task automatic exec_b(input int tok);
    @(negedge clk_i);
    b_ev = 1'b1; b_et = 3'(tok);
    @(posedge clk_i); #1;
    b_ev = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    check(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check(int'(a_free) == 8, "R1", int'(a_free), 8);
    check(int'(a_tok) == 0, "R1", int'(a_tok), 0);
    check(a_rv == 0, "R1", int'(a_rv), 0);

    disp_a(3, 1, 0);
    check(int'(a_free) == 5, "R2", int'(a_free), 5);
    disp_a(0, 1, 3);
    check(int'(a_free) == 5, "R3", int'(a_free), 5);
    disp_a(2, 1, 4);
    check(int'(a_free) == 3, "R2", int'(a_free), 3);
    disp_a(4, 0, 0);
    check(int'(a_free) == 3, "R4", int'(a_free), 3);
    check(int'(a_tok) == 6, "R4", int'(a_tok), 6);

    exec_a(4, 0);
    @(negedge clk_i);
    check(a_rv == 0, "R5", int'(a_rv), 0);
    exec_a(4, 1);
    exec_a(10, 1);
    exec_a(3, 0);
    @(negedge clk_i);
    check(a_rv == 0, "R5", int'(a_rv), 0);
    exec_a(0, 0);
    check(a_rv == 2'b11, "R6", int'(a_rv), 3);
    @(posedge clk_i); #1;
    check(int'(a_free) == 6, "R7", int'(a_free), 6);
    check(a_rv == 2'b01, "R6", int'(a_rv), 1);
    @(posedge clk_i); #1;
    check(int'(a_free) == 8, "R7", int'(a_free), 8);

    disp_a(8, 1, 6);
    check(int'(a_free) == 0, "R2", int'(a_free), 0);
    exec_a(6, 0);
    @(posedge clk_i); #1;
    check(int'(a_free) == 8, "R7", int'(a_free), 8);
    disp_a(5, 1, 14);
    disp_a(0, 1, 3);
    exec_a(14, 0);
    exec_a(3, 0);
    repeat (3) @(posedge clk_i);
    #1;
    check(int'(a_free) == 8, "R7", int'(a_free), 8);
    check(exp_q.size() == 0, "R5", exp_q.size(), 0);

    for (int k = 0; k < 8; k++) disp_b(1, k);
    disp_b(0, 0);
    check(int'(b_free) == 4, "R10", int'(b_free), 4);
    for (int k = 7; k >= 1; k--) exec_b(k);
    @(negedge clk_i);
    check(b_rv == 0, "R5", int'(b_rv), 0);
    exec_b(0);
    check($countones(b_rv) == 8, "R9", $countones(b_rv), 8);
    for (int k = 0; k < 8; k++) check(int'(b_rt[k]) == k, "R9", int'(b_rt[k]), k);
    @(posedge clk_i); #1;
    check(b_rv == 0, "R9", int'(b_rv), 0);
    disp_b(1, 0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule